// File: doc/BRIEF.md
# Asynchronous EPROM Read Sequencer

This block lets synchronous logic fetch single bytes from an asynchronous, byte-wide read-only memory of 32K words. When the host raises a request with a 15-bit address while the block is ready, the block puts the address on the memory pins and pulls the active-low chip select. It then pulls the active-low output gate at the latest point that still meets the output-gate delay. When the chip-select and output-gate delays have both run out, it waits one more cycle for margin and captures the memory's data. The captured byte is returned with a one-cycle valid pulse.

The address, chip-select and output-gate delays are set in nanoseconds together with the clock period, and each is rounded up to whole cycles. After a capture, both strobes rise together. The block then refuses new requests for a float interval, so that a memory releasing the shared data bus never overlaps with the next device driving it. While no access is in progress, chip select stays high so that the memory remains in standby.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: After reset, ready is 1, chip select and output gate are both high (inactive), the valid pulse is 0 and the returned byte is 0x00.
- R2: A request seen while ready is 1 is accepted at that clock edge. From the next cycle the memory address output equals the requested address, chip select is low and ready is 0.
- R3: The output gate goes low only while chip select is low. It first goes low in cycle ACC−OE+1 of the access, where cycle 1 is the first cycle with chip select low and ACC, OE, DF are the rounded cycle counts (6, 4 and 3 with the default values). It stays low until the capture.
- R4: The byte on the memory data input at the end of cycle ACC+1 is captured. In the next cycle the valid output is 1 for exactly one cycle with that byte, and both strobes are high at the same time.
- R5: The memory address and chip select stay constant for all ACC+1 cycles of an access.
- R6: For DF cycles after the strobes rise, ready stays 0 and both strobes stay high. A request held high during this time is accepted only at the edge that ends the first ready cycle, so one access starts every ACC+DF+2 cycles.
- R7: Changes of the request address while an access or float interval is in progress have no effect on the memory address of that access. Chip select is high whenever ready is 1.
- R8: The returned byte keeps its value from one capture to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Host read request |
| addr_i | input | 15 | Host byte address |
| ready_o | output | 1 | Block can accept a request this cycle |
| rvalid_o | output | 1 | One-cycle pulse: rdata_o holds a new byte |
| rdata_o | output | 8 | Last captured byte |
| mem_addr_o | output | 15 | Address pins of the memory |
| mem_ce_n_o | output | 1 | Chip select, active low |
| mem_oe_n_o | output | 1 | Output gate, active low |
| mem_dq_i | input | 8 | Data pins of the memory |

## Verification
The hardest case to reach is a capture one cycle too early or an output gate placed one cycle too late. A simple memory model would still return correct data in both cases. The bench therefore models the memory with its own counters of how long the address, chip select and output gate have each been steady, and it returns the inverted byte until all three delays are met, so any timing slip changes the captured value. Requests are also held high through the float interval, and the address is changed in the middle of an access, so that the back-to-back spacing and the ignored address are both visible on the pins.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_FLOAT  = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
    } strobe_t;

    localparam strobe_t STROBE_OFF = '{ce_n: 1'b1, oe_n: 1'b1};

    function automatic int cyc_ceil(input int delay_ns, input int period_ns);
        return (delay_ns + period_ns - 1) / period_ns;
    endfunction

endpackage

// File: rtl/eprom_rd_timer.sv
module eprom_rd_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic [W-1:0] cnt_o,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);

    // R4: the access countdown advances by exactly one per decrement
    a_r4_dec_step: assert property (@(posedge clk) disable iff (rst)
        (dec_i && !load_i && !zero_o) |=> (cnt_o == $past(cnt_o) - W'(1)));

endmodule

// File: rtl/eprom_rd_seq.sv
module eprom_rd_seq
    import eprom_rd_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int ACC_CYC = 6,
    parameter int OE_CYC  = 4,
    parameter int DF_CYC  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              ready_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output strobe_t           strb_o,
    output logic              capture_o
);

    localparam int CNT_MAX = (ACC_CYC > DF_CYC) ? ACC_CYC : DF_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] ACC_LD = CNT_W'(ACC_CYC);
    localparam logic [CNT_W-1:0] DF_LD  = CNT_W'(DF_CYC);
    localparam logic [CNT_W:0]   OE_LIM = (CNT_W + 1)'(OE_CYC + 1);
    localparam logic OE_AT_START = (ACC_CYC <= OE_CYC);
    localparam logic NO_FLOAT    = (DF_CYC == 0);

    rd_state_e         state_q, state_d;
    strobe_t           strb_q;
    logic [ADDR_W-1:0] addr_q;
    logic              tm_load, tm_dec, tm_zero;
    logic [CNT_W-1:0]  tm_val, tm_cnt;

    eprom_rd_timer #(.W(CNT_W)) i_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tm_load),
        .load_val_i (tm_val),
        .dec_i      (tm_dec),
        .cnt_o      (tm_cnt),
        .zero_o     (tm_zero)
    );

    always_comb begin
        state_d = state_q;
        tm_load = 1'b0;
        tm_val  = ACC_LD;
        tm_dec  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    tm_load = 1'b1;
                    state_d = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                if (tm_zero) begin
                    if (NO_FLOAT) begin
                        state_d = ST_IDLE;
                    end else begin
                        tm_load = 1'b1;
                        tm_val  = DF_LD;
                        state_d = ST_FLOAT;
                    end
                end else begin
                    tm_dec = 1'b1;
                end
            end
            ST_FLOAT: begin
                if (tm_zero || (tm_cnt == CNT_W'(1))) begin
                    state_d = ST_IDLE;
                end else begin
                    tm_dec = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            strb_q  <= STROBE_OFF;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            case (state_q)
                ST_IDLE: begin
                    if (req_i) begin
                        addr_q      <= addr_i;
                        strb_q.ce_n <= 1'b0;
                        strb_q.oe_n <= !OE_AT_START;
                    end
                end
                ST_ACCESS: begin
                    if (tm_zero) begin
                        strb_q <= STROBE_OFF;
                    end else if ({1'b0, tm_cnt} <= OE_LIM) begin
                        strb_q.oe_n <= 1'b0;
                    end
                end
                default: strb_q <= STROBE_OFF;
            endcase
        end
    end

    assign ready_o    = (state_q == ST_IDLE);
    assign capture_o  = (state_q == ST_ACCESS) && tm_zero;
    assign mem_addr_o = addr_q;
    assign strb_o     = strb_q;

    // R3: output gate only under an active chip select
    a_r3_oe_needs_ce: assert property (@(posedge clk) disable iff (rst)
        !strb_q.oe_n |-> !strb_q.ce_n);

    // R5: address steady after the first access cycle
    a_r5_addr_held: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACCESS && tm_cnt != ACC_LD) |-> $stable(addr_q));

    // R5: chip select stays low until the capture cycle
    a_r5_ce_held: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACCESS && !tm_zero) |=> !strb_q.ce_n);

    // R6: bus released during the float interval
    a_r6_float_released: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FLOAT) |-> (strb_q.ce_n && strb_q.oe_n));

    // R7: standby whenever a request could be accepted
    a_r7_idle_standby: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> strb_q.ce_n);

endmodule

// File: rtl/eprom_rd_capture.sv
module eprom_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic              rvalid_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= capture_i;
            if (capture_i) begin
                rdata_q <= dq_i;
            end
        end
    end

    assign rvalid_o = rvalid_q;
    assign rdata_o  = rdata_q;

    // R4: the valid output never lasts two cycles
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rvalid_o |=> !rvalid_o);

    // R8: returned byte only moves on a capture
    a_r8_data_hold: assert property (@(posedge clk) disable iff (rst)
        !capture_i |=> $stable(rdata_o));

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 10,
    parameter int T_ACC_NS  = 55,
    parameter int T_OE_NS   = 35,
    parameter int T_DF_NS   = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              ready_o,
    output logic              rvalid_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_ce_n_o,
    output logic              mem_oe_n_o,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int ACC_CYC = cyc_ceil(T_ACC_NS, CLK_NS);
    localparam int OE_CYC  = cyc_ceil(T_OE_NS, CLK_NS);
    localparam int DF_CYC  = cyc_ceil(T_DF_NS, CLK_NS);

    strobe_t strb;
    logic    capture;

    eprom_rd_seq #(
        .ADDR_W  (ADDR_W),
        .ACC_CYC (ACC_CYC),
        .OE_CYC  (OE_CYC),
        .DF_CYC  (DF_CYC)
    ) i_seq (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req_i),
        .addr_i     (addr_i),
        .ready_o    (ready_o),
        .mem_addr_o (mem_addr_o),
        .strb_o     (strb),
        .capture_o  (capture)
    );

    eprom_rd_capture #(.DATA_W(DATA_W)) i_capture (
        .clk       (clk),
        .rst       (rst),
        .capture_i (capture),
        .dq_i      (mem_dq_i),
        .rvalid_o  (rvalid_o),
        .rdata_o   (rdata_o)
    );

    assign mem_ce_n_o = strb.ce_n;
    assign mem_oe_n_o = strb.oe_n;

endmodule

// File: tb/test_eprom_rd_ctrl.sv
module test_eprom_rd_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int ACC = 6;   // ceil(55/10)
    localparam int OE  = 4;   // ceil(35/10)
    localparam int DF  = 3;   // ceil(25/10)

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [14:0] addr = '0;
    logic        ready, rvalid, ce_n, oe_n;
    logic [7:0]  rdata, mem_dq;
    logic [14:0] mem_addr;

    int vectors = 0;
    int fails   = 0;

    eprom_rd_ctrl i_eprom_rd_ctrl (
        .clk(clk), .rst(rst), .req_i(req), .addr_i(addr),
        .ready_o(ready), .rvalid_o(rvalid), .rdata_o(rdata),
        .mem_addr_o(mem_addr), .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n),
        .mem_dq_i(mem_dq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] content(input logic [14:0] a);
        return a[7:0] ^ {a[14:8], 1'b0} ^ 8'h3C;
    endfunction

    // memory model: data valid only once every delay has been met
    int          ce_age = 0, oe_age = 0, a_age = 0;
    logic [14:0] last_a = '0;
    initial mem_dq = 8'h00;
    always @(negedge clk) begin
        a_age  = (mem_addr != last_a) ? 1 : a_age + 1;
        last_a = mem_addr;
        ce_age = ce_n ? 0 : ce_age + 1;
        oe_age = oe_n ? 0 : oe_age + 1;
        if (!ce_n && !oe_n && ce_age >= ACC + 1 && oe_age >= OE + 1 && a_age >= ACC + 1)
            mem_dq = content(mem_addr);
        else
            mem_dq = ~content(mem_addr);
    end

    // reference model: phase counter per access
    int          t = 0;
    logic        started = 1'b0, acc_evt = 1'b0;
    logic        e_rv = 1'b0;
    logic [7:0]  e_rd = 8'h00;
    logic [14:0] e_addr = '0;
    always @(posedge clk) begin
        started = 1'b1;
        acc_evt = 1'b0;
        if (rst) begin
            t = 0; e_rv = 1'b0; e_rd = 8'h00;
        end else begin
            e_rv = (t == ACC + 1);
            if (e_rv) e_rd = content(e_addr);
            if (t == 0) begin
                if (req) begin t = 1; e_addr = addr; acc_evt = 1'b1; end
            end else if (t == ACC + 1 + DF) t = 0;
            else t = t + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            logic busy;
            busy = (t >= 1 && t <= ACC + 1);
            check("R1/R6 ready", 32'(ready), 32'(t == 0));
            check("R2/R5/R7 ce_n", 32'(ce_n), 32'(!busy));
            check("R3 oe_n", 32'(oe_n), 32'(!(busy && t >= ACC - OE + 1)));
            check("R4 rvalid", 32'(rvalid), 32'(e_rv));
            check("R4/R8 rdata", 32'(rdata), 32'(e_rd));
            if (busy) check("R2/R5/R7 mem_addr", 32'(mem_addr), 32'(e_addr));
        end
    end

    task automatic wait_accept();
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #1;
            if (acc_evt) return;
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #1;
            if (t == 0) return;
        end
    endtask

    task automatic read_one(input logic [14:0] a);
        @(posedge clk); #1;
        req = 1'b1; addr = a;
        wait_accept();
        req = 1'b0;
        wait_idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        repeat (3) @(posedge clk);
        // R2 R3 R4: single reads at corners and patterns
        read_one(15'h0000);
        read_one(15'h7FFF);
        read_one(15'h5555);
        repeat (2) @(posedge clk);
        read_one(15'h2AAA);
        // R6: request held through float, addresses advance per accept
        @(posedge clk); #1;
        req = 1'b1; addr = 15'h0001;
        wait_accept(); addr = 15'h0002;
        wait_accept(); addr = 15'h0003;
        wait_accept(); req = 1'b0;
        wait_idle();
        // R7: address moves during access and float, request dropped mid-way
        @(posedge clk); #1;
        req = 1'b1; addr = 15'h1234;
        wait_accept();
        req = 1'b0; addr = 15'h4321;
        repeat (3) @(posedge clk);
        #1 req = 1'b1; addr = 15'h0F0F;
        wait_accept();
        req = 1'b0;
        wait_idle();
        // R1: reset in the middle of an access
        @(posedge clk); #1;
        req = 1'b1; addr = 15'h0777;
        wait_accept(); req = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        read_one(15'h6001);
        repeat (4) @(posedge clk);
        #1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule